// File: doc/BRIEF.md
# Two-Wire Bus Slave Bit and Byte Engine

This block is the physical front end of a slave on a two-wire open-drain bus. It oversamples the serial clock and data lines with a fast system clock, passes each line through a synchronizer and a stable-count spike filter, and finds start and stop conditions and clock edges on the cleaned signals. Received bits are assembled into words, most significant bit first. The block acknowledges each word in the ninth clock when told to. When the command layer asks for a read, the block shifts words out and samples the master's acknowledge.

The command layer above it sees single-cycle event pulses: start, stop, word received, word request and master acknowledge. It answers with three levels: `ack_en` (acknowledge the word being received), `rd_mode` (send the next word), and `tx_data`. The block never drives the data line high. Its only data output is a pull-low enable for an open-drain pad. Any start condition, even one in the middle of a word, clears the bit counter and begins a new reception. This gives the bus a way to recover after a lost transfer.

Top module: `twi_slave_phy`

## Requirements
- R1: After reset, `sda_oe` is 0 and no event output (`evt_start`, `evt_stop`, `rx_valid`, `byte_req`, `mack_valid`) pulses while both lines stay high.
- R2: A high-to-low change of the filtered data line while the filtered clock is high gives a one-cycle `evt_start` pulse.
- R3: A low-to-high change of the filtered data line while the filtered clock is high gives a one-cycle `evt_stop` pulse. After it, `sda_oe` is 0.
- R4: During reception, data is sampled on each filtered clock rising edge, most significant bit first. On the eighth rising edge, `rx_valid` pulses for one cycle and `rx_data` holds the word.
- R5: In receive mode, `ack_en` is sampled at the falling edge that ends the eighth bit, and `sda_oe` takes that value for the ninth clock. `sda_oe` returns to 0 after the ninth falling edge unless a transmit word starts.
- R6: `byte_req` pulses once on the rising edge of every ninth clock, except when the master has just refused a transmitted word.
- R7: If `rd_mode` is 1 at the falling edge that ends a ninth clock, `tx_data` is loaded and sent most significant bit first. Each bit is presented after a filtered falling edge, with `sda_oe` = 1 for a 0 bit and `sda_oe` = 0 for a 1 bit.
- R8: While transmitting, the ninth rising edge gives a `mack_valid` pulse. `mack_nack` then equals the data line level (0 = master acknowledge, 1 = refusal).
- R9: After a refusal, the block keeps `sda_oe` at 0, ignores clock edges and issues no `byte_req` until the next start or stop.
- R10: A pulse on either line that lasts fewer than `FILT_LEN` system clocks has no effect on events or received data.
- R11: A start condition in the middle of a word discards the partial word and clears the bit count. The next eight bits then form one complete word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| ack_en | input | 1 | Acknowledge the word now being received |
| rd_mode | input | 1 | Send a word after the current ninth clock |
| tx_data | input | WORD_W | Word to send, taken at the end of the ninth clock |
| evt_start | output | 1 | Start condition pulse |
| evt_stop | output | 1 | Stop condition pulse |
| rx_valid | output | 1 | Received word pulse |
| rx_data | output | WORD_W | Last received word |
| byte_req | output | 1 | Ninth-clock pulse: prepare `rd_mode`/`tx_data` |
| mack_valid | output | 1 | Master acknowledge sampled |
| mack_nack | output | 1 | 1 when the master refused the last sent word |

## Verification
A start condition and a data-sampling clock edge can both act on the bit counter close together. A repeated start that follows a partly received word lands right after a rising edge that has just added one more bit. The bench sends four bits, then raises the clock and pulls data low for a repeated start, and then sends a complete word. The test passes if exactly one `rx_valid` follows and it carries that complete word, with nothing left over from the discarded fragment.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RX   = 2'd1,
    ST_TX   = 2'd2,
    ST_WAIT = 2'd3
  } twi_state_e;
endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
  parameter int  FILT_LEN = 3,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= {2{RST_VAL}};
      dout   <= RST_VAL;
      run_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], din};
      if (sync_q[1] == dout) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_LEN - 1)) begin
        dout  <= sync_q[1];
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  // R10: the output only moves to a level the synchronized input actually held
  assert_filter_follows_R10: assert property (@(posedge clk) disable iff (rst)
    (dout != $past(dout)) |-> ($past(sync_q[1]) == dout));
endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_p,
  output logic stop_p,
  output logic rise_p,
  output logic fall_p
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  always_comb begin
    start_p = scl_f & scl_q & sda_q & ~sda_f;
    stop_p  = scl_f & scl_q & ~sda_q & sda_f;
    rise_p  = scl_f & ~scl_q;
    fall_p  = ~scl_f & scl_q;
  end
endmodule

// File: rtl/twi_byte_engine.sv
module twi_byte_engine
  import twi_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic              rise_p,
  input  logic              fall_p,
  input  logic              sda_f,
  input  logic              ack_en,
  input  logic              rd_mode,
  input  logic [WORD_W-1:0] tx_data,
  output logic              sda_oe,
  output logic              evt_start,
  output logic              evt_stop,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data,
  output logic              byte_req,
  output logic              mack_valid,
  output logic              mack_nack
);
  localparam int CNT_W   = $clog2(WORD_W + 2);
  localparam int ACK_IDX = WORD_W;
  localparam int END_IDX = WORD_W + 1;

  twi_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] rx_sh_q;
  logic [WORD_W-1:0] tx_sh_q;
  logic              active;

  assign active = (state_q == ST_RX) || (state_q == ST_TX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      rx_sh_q    <= '0;
      tx_sh_q    <= '0;
      rx_data    <= '0;
      sda_oe     <= 1'b0;
      evt_start  <= 1'b0;
      evt_stop   <= 1'b0;
      rx_valid   <= 1'b0;
      byte_req   <= 1'b0;
      mack_valid <= 1'b0;
      mack_nack  <= 1'b0;
    end else begin
      evt_start  <= 1'b0;
      evt_stop   <= 1'b0;
      rx_valid   <= 1'b0;
      byte_req   <= 1'b0;
      mack_valid <= 1'b0;
      if (start_p) begin
        state_q   <= ST_RX;
        cnt_q     <= '0;
        sda_oe    <= 1'b0;
        evt_start <= 1'b1;
      end else if (stop_p) begin
        state_q  <= ST_IDLE;
        cnt_q    <= '0;
        sda_oe   <= 1'b0;
        evt_stop <= 1'b1;
      end else if (rise_p && active) begin
        if (cnt_q < CNT_W'(ACK_IDX)) begin
          cnt_q <= cnt_q + 1'b1;
          if (state_q == ST_RX) begin
            rx_sh_q <= {rx_sh_q[WORD_W-2:0], sda_f};
            if (cnt_q == CNT_W'(ACK_IDX - 1)) begin
              rx_valid <= 1'b1;
              rx_data  <= {rx_sh_q[WORD_W-2:0], sda_f};
            end
          end
        end else if (cnt_q == CNT_W'(ACK_IDX)) begin
          cnt_q <= CNT_W'(END_IDX);
          if (state_q == ST_TX) begin
            mack_valid <= 1'b1;
            mack_nack  <= sda_f;
          end
          byte_req <= !((state_q == ST_TX) && sda_f);
        end
      end else if (fall_p && active) begin
        if (cnt_q == CNT_W'(ACK_IDX)) begin
          sda_oe <= (state_q == ST_RX) ? ack_en : 1'b0;
        end else if (cnt_q == CNT_W'(END_IDX)) begin
          cnt_q <= '0;
          if ((state_q == ST_TX) && mack_nack) begin
            state_q <= ST_WAIT;
            sda_oe  <= 1'b0;
          end else if (rd_mode) begin
            state_q <= ST_TX;
            tx_sh_q <= tx_data;
            sda_oe  <= ~tx_data[WORD_W-1];
          end else begin
            state_q <= ST_RX;
            sda_oe  <= 1'b0;
          end
        end else if ((state_q == ST_TX) && (cnt_q != '0)) begin
          tx_sh_q <= {tx_sh_q[WORD_W-2:0], 1'b0};
          sda_oe  <= ~tx_sh_q[WORD_W-2];
        end
      end
    end
  end

  // R4: a received word is reported exactly when the eighth bit has been counted
  assert_rx_at_eighth_R4: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (cnt_q == CNT_W'(ACK_IDX)) && (state_q == ST_RX));
  // R8: master acknowledge is only reported for a word this block sent
  assert_mack_in_tx_R8: assert property (@(posedge clk) disable iff (rst)
    mack_valid |-> ($past(state_q) == ST_TX));
  // R9: after a refusal the line stays released and no request is raised
  assert_wait_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT) |-> (!sda_oe && !byte_req && !rx_valid));
  // R2: event pulses never overlap
  assert_events_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({evt_start, evt_stop, rx_valid, mack_valid}));
  // R11: a start leaves the counter cleared in receive mode
  assert_start_resync_R11: assert property (@(posedge clk) disable iff (rst)
    evt_start |-> (cnt_q == '0) && (state_q == ST_RX) && !sda_oe);
  // R6: a request pulse belongs to the ninth clock
  assert_req_in_ninth_R6: assert property (@(posedge clk) disable iff (rst)
    byte_req |-> (cnt_q == CNT_W'(END_IDX)));
endmodule

// File: rtl/twi_slave_phy.sv
module twi_slave_phy #(
  parameter int FILT_LEN = 3,
  parameter int WORD_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              ack_en,
  input  logic              rd_mode,
  input  logic [WORD_W-1:0] tx_data,
  output logic              evt_start,
  output logic              evt_stop,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data,
  output logic              byte_req,
  output logic              mack_valid,
  output logic              mack_nack
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] line_raw;
  logic [N_LINES-1:0] line_f;
  logic start_p, stop_p, rise_p, fall_p;

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_filt
    twi_line_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_filt (
      .clk  (clk),
      .rst  (rst),
      .din  (line_raw[g]),
      .dout (line_f[g])
    );
  end

  twi_cond_detect u_cond (
    .clk     (clk),
    .rst     (rst),
    .scl_f   (line_f[0]),
    .sda_f   (line_f[1]),
    .start_p (start_p),
    .stop_p  (stop_p),
    .rise_p  (rise_p),
    .fall_p  (fall_p)
  );

  twi_byte_engine #(.WORD_W(WORD_W)) u_eng (
    .clk        (clk),
    .rst        (rst),
    .start_p    (start_p),
    .stop_p     (stop_p),
    .rise_p     (rise_p),
    .fall_p     (fall_p),
    .sda_f      (line_f[1]),
    .ack_en     (ack_en),
    .rd_mode    (rd_mode),
    .tx_data    (tx_data),
    .sda_oe     (sda_oe),
    .evt_start  (evt_start),
    .evt_stop   (evt_stop),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .byte_req   (byte_req),
    .mack_valid (mack_valid),
    .mack_nack  (mack_nack)
  );

  // R3: a stop always leaves the data line released
  assert_stop_release_R3: assert property (@(posedge clk) disable iff (rst)
    evt_stop |-> !sda_oe);
endmodule

// File: tb/twi_slave_phy_test.sv
module twi_slave_phy_test;
  localparam int FILT = 3;
  localparam int Q = 12;
  localparam int H = 24;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic ack_en = 1'b1, rd_mode = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic sda_oe, evt_start, evt_stop, rx_valid, byte_req, mack_valid, mack_nack;
  logic [7:0] rx_data;
  wire sda_line = sda_m & ~sda_oe;

  twi_slave_phy #(.FILT_LEN(FILT), .WORD_W(8)) uut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .ack_en(ack_en), .rd_mode(rd_mode), .tx_data(tx_data),
    .evt_start(evt_start), .evt_stop(evt_stop), .rx_valid(rx_valid),
    .rx_data(rx_data), .byte_req(byte_req), .mack_valid(mack_valid),
    .mack_nack(mack_nack)
  );

  int errors = 0, checks = 0;
  int n_start = 0, n_stop = 0, n_rx = 0, n_req = 0, n_mack = 0;
  logic [7:0] last_rx = 8'h00;
  logic last_nack = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (evt_start) n_start++;
      if (evt_stop) n_stop++;
      if (rx_valid) begin n_rx++; last_rx = rx_data; end
      if (byte_req) n_req++;
      if (mack_valid) begin n_mack++; last_nack = mack_nack; end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; wclk(Q);
    scl_m = 1'b1; wclk(H);
    sda_m = 1'b0; wclk(H);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; wclk(Q);
    scl_m = 1'b1; wclk(H);
    sda_m = 1'b1; wclk(H);
  endtask

  task automatic m_bit(input logic b);
    sda_m = b; wclk(Q);
    scl_m = 1'b1; wclk(H);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic m_write(input logic [7:0] d, input int glitch_at, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      m_bit(d[i]);
      if (i == glitch_at) begin
        scl_m = 1'b1; wclk(FILT - 1);
        scl_m = 1'b0; wclk(Q);
      end
    end
    sda_m = 1'b1; wclk(Q);
    scl_m = 1'b1; wclk(H / 2);
    acked = !sda_line;
    wclk(H / 2);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic m_read(input logic give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wclk(Q);
      scl_m = 1'b1; wclk(H / 2);
      d[i] = sda_line;
      wclk(H / 2);
      scl_m = 1'b0; wclk(Q);
    end
    m_bit(!give_ack);
    sda_m = 1'b1;
  endtask

  task automatic t_reset();
    check(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
    check(n_start + n_stop + n_rx + n_req + n_mack == 0, "R1 no events",
          n_start + n_stop + n_rx + n_req + n_mack, 0);
  endtask

  task automatic t_write();
    logic ak;
    ack_en = 1'b1; rd_mode = 1'b0;
    m_start();
    check(n_start == 1, "R2 start pulse", n_start, 1);
    m_write(8'hA6, -1, ak);
    check(ak == 1'b1, "R5 ack driven", ak, 1);
    check(n_rx == 1 && last_rx == 8'hA6, "R4 word received", last_rx, 8'hA6);
    check(n_req == 1, "R6 request in ninth clock", n_req, 1);
    check(sda_oe == 1'b0, "R5 release after ninth", sda_oe, 0);
    ack_en = 1'b0;
    m_write(8'h3C, -1, ak);
    check(ak == 1'b0, "R5 no ack when disabled", ak, 0);
    check(n_rx == 2 && last_rx == 8'h3C, "R4 second word", last_rx, 8'h3C);
    m_stop();
    check(n_stop == 1, "R3 stop pulse", n_stop, 1);
    check(sda_oe == 1'b0, "R3 released after stop", sda_oe, 0);
  endtask

  task automatic t_read();
    logic ak;
    logic [7:0] d;
    int req_snap;
    ack_en = 1'b1; rd_mode = 1'b1; tx_data = 8'h96;
    m_start();
    m_write(8'hA1, -1, ak);
    check(ak == 1'b1, "R5 address ack", ak, 1);
    tx_data = 8'h5B;
    m_read(1'b1, d);
    check(d == 8'h96, "R7 first sent word", d, 8'h96);
    check(n_mack == 1 && last_nack == 1'b0, "R8 master ack seen", last_nack, 0);
    req_snap = n_req;
    m_read(1'b0, d);
    check(d == 8'h5B, "R7 second sent word", d, 8'h5B);
    check(n_mack == 2 && last_nack == 1'b1, "R8 master refusal seen", last_nack, 1);
    m_read(1'b1, d);
    check(d == 8'hFF, "R9 silent after refusal", d, 8'hFF);
    check(n_req == req_snap, "R9 no request after refusal", n_req, req_snap);
    check(sda_oe == 1'b0, "R9 line released", sda_oe, 0);
    rd_mode = 1'b0;
    m_stop();
    check(n_stop == 2, "R3 stop after read", n_stop, 2);
  endtask

  task automatic t_glitch();
    logic ak;
    int s0, p0, r0;
    s0 = n_start; p0 = n_stop;
    sda_m = 1'b0; wclk(FILT - 1);
    sda_m = 1'b1; wclk(H);
    check(n_start == s0 && n_stop == p0, "R10 data spike ignored", n_start - s0, 0);
    ack_en = 1'b1;
    m_start();
    r0 = n_rx;
    m_write(8'hC3, 3, ak);
    check(n_rx == r0 + 1 && last_rx == 8'hC3, "R10 clock spike ignored", last_rx, 8'hC3);
    m_stop();
  endtask

  task automatic t_resync();
    logic ak;
    int s0, r0;
    s0 = n_start;
    m_start();
    m_bit(1'b1); m_bit(1'b0); m_bit(1'b1); m_bit(1'b1);
    r0 = n_rx;
    m_start();
    check(n_start == s0 + 2, "R11 repeated start seen", n_start - s0, 2);
    m_write(8'h5A, -1, ak);
    check(n_rx == r0 + 1, "R11 one word after resync", n_rx - r0, 1);
    check(last_rx == 8'h5A, "R11 word intact", last_rx, 8'h5A);
    m_stop();
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wclk(5);
    rst = 1'b0;
    wclk(H);
    t_reset();
    t_write();
    t_read();
    t_glitch();
    t_resync();
    wclk(10);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule